// File: doc/BRIEF.md
# Microcode Pointer Stack

This block is a small register-file stack for a microsequencer. It holds sixteen 16-bit words and a 4-bit pointer. Microcode uses it two ways. As a last-in first-out stack, it holds saved values and subroutine return addresses. As a scratch pad, it is addressed by the pointer alone. One enable input chooses between the two uses on each access. When that enable is set, a write also moves the pointer down and a read also moves it up. When it is clear, the pointer stays where it is.

The word to be stored comes through a 2:1 selector. One input is the external data bus and the other is the shifter output. The word at the pointer is always present on the top-of-stack output. Its low eleven bits also appear on a separate output, which carries return addresses back to the sequencer. The pointer can be loaded from a 4-bit literal taken from the microinstruction. The pointer has no guard against overflow or underflow. It powers up with an undefined value, and reset does not clear it.

Top module: `ustk_top`

## Requirements
- R1: The store holds 16 words of 16 bits, and `tos` always shows the word at the address held in `ptr`, with no clock delay.
- R2: A push (`wr_en`=1, `pp_en`=1, `rd_en`=0) lowers the pointer by one and writes the selected word into that new location on the same edge.
- R3: A pop (`rd_en`=1, `pp_en`=1, `wr_en`=0) presents the word at the current pointer on `tos` during the cycle and raises the pointer by one at the edge.
- R4: With `pp_en`=0, a write stores at the current pointer and a read only observes `tos`, and the pointer keeps its value in both cases.
- R5: When `ld_en`=1, the pointer takes `ld_val` at the edge, overriding any move from a push or pop in the same cycle. A write in that cycle still uses the address computed from the old pointer.
- R6: The pointer wraps modulo 16: a push at 0 goes to 15, and a pop at 15 goes to 0.
- R7: The word written is `bus_data` when `src_sel`=0 and `shf_data` when `src_sel`=1.
- R8: `ret_addr` always equals bits 10 down to 0 of `tos`.
- R9: A read and a write together with `pp_en`=1 replace the top word in place: the selected word is stored at the current pointer and the pointer does not change.
- R10: Reset clears neither the pointer nor the stored words, so the pointer and `tos` read the same after a reset pulse as before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset (used only by the optional pointer-reset variant) |
| rd_en | input | 1 | Read access |
| wr_en | input | 1 | Write access |
| pp_en | input | 1 | Access also moves the pointer (push on write, pop on read) |
| ld_en | input | 1 | Load pointer from literal |
| ld_val | input | 4 | Pointer literal |
| src_sel | input | 1 | Write data source: 0 bus, 1 shifter |
| bus_data | input | 16 | External data bus word |
| shf_data | input | 16 | Shifter output word |
| tos | output | 16 | Word at the pointer |
| ptr | output | 4 | Current pointer |
| ret_addr | output | 11 | Low 11 bits of `tos`, return address |

## Verification
The pointer has no defined value until its first load, so the checker treats every pointer-motion property as vacuous until it has seen `ld_en` since reset. It also relies on the inputs being known at every clock edge. The bench issues a load before its first access and then drives only fully known values. In the random phase, every combination of read, write, enable and load is allowed, including wrap-around at both ends. Any stored word the bench has not yet written is left out of its data comparisons.

// File: rtl/ustk_pkg.sv
package ustk_pkg;

   // Pointer motion decoded from one access
   typedef enum logic [1:0] {
      MV_HOLD = 2'd0,   // no pointer change
      MV_PUSH = 2'd1,   // pre-decrement, write new location
      MV_POP  = 2'd2,   // read current, post-increment
      MV_REPL = 2'd3    // read and write together: overwrite top in place
   } ustk_move_e;

   localparam int USTK_DEF_DATA_W = 16;
   localparam int USTK_DEF_DEPTH  = 16;
   localparam int USTK_DEF_RET_W  = 11;

endpackage

// File: rtl/ustk_decode.sv
module ustk_decode
   import ustk_pkg::*;
(
   input  logic       rd_en,
   input  logic       wr_en,
   input  logic       pp_en,
   output ustk_move_e move
);

   always_comb begin
      move = MV_HOLD;
      if (pp_en) begin
         unique case ({rd_en, wr_en})
            2'b01:   move = MV_PUSH;
            2'b10:   move = MV_POP;
            2'b11:   move = MV_REPL;
            default: move = MV_HOLD;
         endcase
      end
   end

endmodule

// File: rtl/ustk_src_sel.sv
module ustk_src_sel #(
   parameter int DATA_W = 16
) (
   input  logic              src_sel,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [DATA_W-1:0] shf_data,
   output logic [DATA_W-1:0] wdata
);

   assign wdata = src_sel ? shf_data : bus_data;

endmodule

// File: rtl/ustk_ptr.sv
module ustk_ptr
   import ustk_pkg::*;
#(
   parameter int              PTR_W   = 4,
   parameter bit              RST_EN  = 1'b0,
   parameter logic [PTR_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ustk_move_e       move,
   input  logic             ld_en,
   input  logic [PTR_W-1:0] ld_val,
   output logic [PTR_W-1:0] ptr_q,
   output logic [PTR_W-1:0] ptr_dn
);

   logic [PTR_W-1:0] ptr_up;
   logic [PTR_W-1:0] ptr_nxt;

   // Modulo arithmetic: no overflow or underflow guard
   assign ptr_dn = ptr_q - PTR_W'(1);
   assign ptr_up = ptr_q + PTR_W'(1);

   always_comb begin
      if (ld_en) begin
         ptr_nxt = ld_val;             // literal load wins
      end else begin
         unique case (move)
            MV_PUSH: ptr_nxt = ptr_dn;
            MV_POP:  ptr_nxt = ptr_up;
            default: ptr_nxt = ptr_q;
         endcase
      end
   end

   generate
      if (RST_EN) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ptr_q <= RST_VAL;
            else        ptr_q <= ptr_nxt;
         end
      end else begin : g_norst
         // Pointer is undefined until loaded; reset leaves it alone
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            ptr_q <= ptr_nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/ustk_rf.sv
module ustk_rf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DEPTH-1:0][DATA_W-1:0] words;

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
         logic              hit;
         logic [DATA_W-1:0] word_q;
         assign hit = we && (waddr == ADDR_W'(gi));
         always_ff @(posedge clk) begin
            if (hit) word_q <= wdata;
         end
         assign words[gi] = word_q;
      end
   endgenerate

   assign rdata = words[raddr];

endmodule

// File: rtl/ustk_top.sv
module ustk_top
   import ustk_pkg::*;
#(
   parameter int DATA_W     = USTK_DEF_DATA_W,
   parameter int DEPTH      = USTK_DEF_DEPTH,
   parameter int RET_W      = USTK_DEF_RET_W,
   parameter bit PTR_RST_EN = 1'b0,
   localparam int PTR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              pp_en,
   input  logic              ld_en,
   input  logic [PTR_W-1:0]  ld_val,
   input  logic              src_sel,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [DATA_W-1:0] shf_data,
   output logic [DATA_W-1:0] tos,
   output logic [PTR_W-1:0]  ptr,
   output logic [RET_W-1:0]  ret_addr
);

   // Elaboration-time parameter checks
   generate
      if (DEPTH < 2 || DEPTH != (1 << PTR_W)) begin : g_bad_depth
         $error("ustk_top: DEPTH must be a power of two of at least 2");
      end
      if (RET_W < 1 || RET_W > DATA_W) begin : g_bad_ret
         $error("ustk_top: RET_W must lie in 1..DATA_W");
      end
   endgenerate

   ustk_move_e        move;
   logic [DATA_W-1:0] wdata;
   logic [PTR_W-1:0]  ptr_q;
   logic [PTR_W-1:0]  ptr_dn;
   logic [PTR_W-1:0]  waddr;

   ustk_decode u_dec (
      .rd_en (rd_en),
      .wr_en (wr_en),
      .pp_en (pp_en),
      .move  (move)
   );

   ustk_src_sel #(.DATA_W(DATA_W)) u_sel (
      .src_sel  (src_sel),
      .bus_data (bus_data),
      .shf_data (shf_data),
      .wdata    (wdata)
   );

   ustk_ptr #(.PTR_W(PTR_W), .RST_EN(PTR_RST_EN)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .move   (move),
      .ld_en  (ld_en),
      .ld_val (ld_val),
      .ptr_q  (ptr_q),
      .ptr_dn (ptr_dn)
   );

   // Push writes the pre-decremented slot; every other write uses the pointer
   assign waddr = (move == MV_PUSH) ? ptr_dn : ptr_q;

   ustk_rf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(PTR_W)) u_rf (
      .clk   (clk),
      .we    (wr_en),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (ptr_q),
      .rdata (tos)
   );

   assign ptr      = ptr_q;
   assign ret_addr = tos[RET_W-1:0];

endmodule

// File: rtl/ustk_chk.sv
module ustk_chk #(
   parameter int DATA_W = 16,
   parameter int PTR_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              wr_en,
   input logic              pp_en,
   input logic              ld_en,
   input logic [PTR_W-1:0]  ld_val,
   input logic              src_sel,
   input logic [DATA_W-1:0] bus_data,
   input logic [DATA_W-1:0] shf_data,
   input logic [DATA_W-1:0] tos,
   input logic [PTR_W-1:0]  ptr
);

   // Pointer value is meaningful only once a load has been seen
   logic seen_ld;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     seen_ld <= 1'b0;
      else if (ld_en) seen_ld <= 1'b1;
   end

   logic is_push, is_pop, is_still;
   assign is_push  = seen_ld && !ld_en && pp_en && wr_en && !rd_en;
   assign is_pop   = seen_ld && !ld_en && pp_en && rd_en && !wr_en;
   assign is_still = seen_ld && !ld_en && !(pp_en && (rd_en ^ wr_en));

   p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_push |=> ptr == PTR_W'($past(ptr) - 1));

   p_push_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_push |=> tos == $past(src_sel ? shf_data : bus_data));

   p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_pop |=> ptr == PTR_W'($past(ptr) + 1));

   p_hold_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_still |=> $stable(ptr));

   p_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_still && !wr_en) |=> $stable(tos));

   p_load_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> ptr == $past(ld_val));

   p_replace_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_ld && !ld_en && pp_en && rd_en && wr_en)
         |=> tos == $past(src_sel ? shf_data : bus_data));

endmodule

bind ustk_top ustk_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .pp_en    (pp_en),
   .ld_en    (ld_en),
   .ld_val   (ld_val),
   .src_sel  (src_sel),
   .bus_data (bus_data),
   .shf_data (shf_data),
   .tos      (tos),
   .ptr      (ptr)
);

// File: tb/ustk_top_bench.sv
module ustk_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 16;
   localparam int DEPTH      = 16;
   localparam int PTR_W      = 4;
   localparam int RET_W      = 11;
   localparam int N_RAND     = 3000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_en = 0, wr_en = 0, pp_en = 0, ld_en = 0, src_sel = 0;
   logic [PTR_W-1:0]  ld_val = '0;
   logic [DATA_W-1:0] bus_data = '0, shf_data = '0;
   logic [DATA_W-1:0] tos;
   logic [PTR_W-1:0]  ptr;
   logic [RET_W-1:0]  ret_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   ustk_top u_ustk_top (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .pp_en(pp_en),
      .ld_en(ld_en), .ld_val(ld_val), .src_sel(src_sel), .bus_data(bus_data),
      .shf_data(shf_data), .tos(tos), .ptr(ptr), .ret_addr(ret_addr)
   );

   // Bench model
   logic [DATA_W-1:0] m_mem [DEPTH];
   bit                m_vld [DEPTH];
   logic [PTR_W-1:0]  m_ptr;
   bit                m_ptr_ok = 0;
   int                checks = 0, fails = 0;
   bit                done = 0;

   function automatic logic [PTR_W-1:0] f_next_ptr(logic [PTR_W-1:0] p, bit rd, bit wr,
                                                    bit pp, bit ld, logic [PTR_W-1:0] lit);
      if (ld) return lit;
      if (pp && wr && !rd) return p - PTR_W'(1);
      if (pp && rd && !wr) return p + PTR_W'(1);
      return p;
   endfunction

   function automatic logic [PTR_W-1:0] f_waddr(logic [PTR_W-1:0] p, bit rd, bit wr, bit pp);
      return (pp && wr && !rd) ? p - PTR_W'(1) : p;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic check_outs(string tag);
      if (m_ptr_ok) chk({tag, " ptr"}, 32'(ptr), 32'(m_ptr));
      if (m_ptr_ok && m_vld[m_ptr]) chk({tag, " tos"}, 32'(tos), 32'(m_mem[m_ptr]));
      chk("R8 ret_addr slice", 32'(ret_addr), 32'(tos[RET_W-1:0]));
   endtask

   task automatic step(string tag, bit rd, bit wr, bit pp, bit ld, logic [PTR_W-1:0] lit,
                       bit sel, logic [DATA_W-1:0] bd, logic [DATA_W-1:0] sd);
      logic [PTR_W-1:0] wa;
      rd_en = rd; wr_en = wr; pp_en = pp; ld_en = ld; ld_val = lit;
      src_sel = sel; bus_data = bd; shf_data = sd;
      #1;
      if (rd && m_ptr_ok && m_vld[m_ptr])
         chk({tag, " R3 pre-edge top"}, 32'(tos), 32'(m_mem[m_ptr]));
      @(posedge clk);
      if (wr && m_ptr_ok) begin
         wa = f_waddr(m_ptr, rd, wr, pp);
         m_mem[wa] = sel ? sd : bd;
         m_vld[wa] = 1;
      end
      m_ptr = f_next_ptr(m_ptr, rd, wr, pp, ld, lit);
      if (ld) m_ptr_ok = 1;
      @(negedge clk);
      rd_en = 0; wr_en = 0; pp_en = 0; ld_en = 0;
      check_outs(tag);
   endtask

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [PTR_W-1:0]  p_before;
      logic [DATA_W-1:0] t_before;
      void'($urandom(32'h1d5e_a7c3));
      for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: first load defines the pointer
      step("R5 initial load", 0, 0, 0, 1, 4'd5, 0, '0, '0);
      step("R5 reload to 0", 0, 0, 0, 1, 4'd0, 0, '0, '0);

      // R1 R4 R7 R5: scratch write at pointer while loading next address
      for (int i = 0; i < DEPTH; i++)
         step(i[0] ? "R7 shifter source" : "R7 bus source", 0, 1, 0, 1, PTR_W'(i + 1),
              i[0], DATA_W'(16'hA000 + i * 17), DATA_W'(16'h5100 + i * 3));

      // R4: scratch read without pointer motion
      step("R4 load 3", 0, 0, 0, 1, 4'd3, 0, '0, '0);
      step("R4 plain read", 1, 0, 0, 0, '0, 0, '0, '0);
      step("R4 plain read again", 1, 0, 0, 0, '0, 0, '0, '0);
      step("R4 plain write", 0, 1, 0, 0, '0, 0, 16'hBEEF, '0);
      step("R1 top word", 0, 0, 0, 0, '0, 0, '0, '0);

      // R2 R6: push from 0 wraps to 15
      step("R6 load 0", 0, 0, 0, 1, 4'd0, 0, '0, '0);
      step("R6 push wraps to 15", 0, 1, 1, 0, '0, 0, 16'h1234, '0);
      step("R2 push", 0, 1, 1, 0, '0, 1, '0, 16'h0FED);

      // R3 R6: pops
      step("R3 pop", 1, 0, 1, 0, '0, 0, '0, '0);
      step("R6 pop wraps to 0", 1, 0, 1, 0, '0, 0, '0, '0);

      // R9: replace top in place
      step("R9 replace top", 1, 1, 1, 0, '0, 0, 16'h7777, '0);

      // R5: load beats push; write lands at old pointer minus one
      step("R5 load 9", 0, 0, 0, 1, 4'd9, 0, '0, '0);
      step("R5 load over push", 0, 1, 1, 1, 4'd2, 0, 16'h4242, '0);
      step("R5 load 8 to view", 0, 0, 0, 1, 4'd8, 0, '0, '0);
      step("R5 load over pop", 1, 0, 1, 1, 4'd12, 0, '0, '0);

      // R10: reset leaves pointer and words untouched
      p_before = ptr; t_before = tos;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 ptr across reset", 32'(ptr), 32'(p_before));
      chk("R10 tos across reset", 32'(tos), 32'(t_before));
      check_outs("R10 model after reset");

      // Random phase
      for (int n = 0; n < N_RAND; n++) begin
         bit rd, wr, pp, ld, sel;
         string tag;
         rd  = $urandom_range(0, 1);
         wr  = $urandom_range(0, 1);
         pp  = $urandom_range(0, 1);
         ld  = ($urandom_range(0, 7) == 0);
         sel = $urandom_range(0, 1);
         if (ld)                   tag = "R5 rand load";
         else if (pp && rd && wr)  tag = "R9 rand replace";
         else if (pp && wr)        tag = "R2 rand push";
         else if (pp && rd)        tag = "R3 rand pop";
         else                      tag = "R4 rand scratch";
         step(tag, rd, wr, pp, ld, PTR_W'($urandom), sel,
              DATA_W'($urandom), DATA_W'($urandom));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule